// File: doc/BRIEF.md
# Atomic Synchronisation Memory Unit

This unit sits on the memory side of a multi-core system and gives software the primitives it needs to build locks and other synchronisation schemes. A small internal word memory is reached through one request port that has already been arbitrated. Each request carries an opcode, an address and a write value. The unit performs the operation's read-modify-write as one indivisible step, then returns the value the word held before the operation. A conditional store also returns a success flag.

Five atomic forms are provided:

- an exchange;
- a test-and-set that only writes when the word is zero;
- a fetch-and-increment;
- a load that arms a single link register;
- a conditional store that only writes while that link still names its address.

A plain load and a plain store are provided as well, so that lock words can be set up and inspected. The link is cancelled by a context-switch input, by any completed conditional store, and by any write-capable operation that targets the linked word.

Requests are served one at a time. An accepted request holds the unit busy for one cycle, while the word is read and rewritten. The response appears, registered, in the cycle after that.

Top module: `atomic_sync_unit`

## Requirements
- R1: A request is accepted at a rising edge where `req_valid` is 1 and `busy` is 0. `busy` is then 1 for exactly one cycle. In the following cycle `rsp_valid` is 1 for exactly one cycle. Any request presented while `busy` is 1 is ignored and writes nothing.
- R2: `req_op` is encoded as follows: 0 load, 1 store, 2 swap, 3 test-and-set, 4 fetch-and-increment, 5 load-linked, 6 store-conditional, 7 reserved. For every opcode, `rsp_rdata` is the value the addressed word held before the operation. The reserved code writes nothing and leaves the link unchanged.
- R3: Swap writes `req_wdata` to the word. With the lock convention of 0 meaning free and 1 meaning held, a swap of 1 that returns 0 acquires the lock, and a second swap of 1 returns 1.
- R4: Test-and-set writes 1 only when the prior value is 0. Any nonzero word is left unchanged.
- R5: Fetch-and-increment stores the prior value plus one, modulo 2^DW, so an all-ones word becomes 0. The convention is that 0 means free and a value above 0 means in use.
- R6: Load-linked records its address in the link register and makes the link valid. A later load-linked replaces the recorded address.
- R7: Store-conditional writes `req_wdata` only when the link is valid and holds the same address. `rsp_status` is 1 on success and 0 on failure. `rsp_status` is 0 for every other opcode. A store-conditional clears the link whether it succeeds or not.
- R8: `ctx_switch` high at a rising edge clears the link. This takes priority over a load-linked or store-conditional completing at the same edge, which sets no link and fails respectively.
- R9: A store, swap, test-and-set or fetch-and-increment to the linked address clears the link. A load to any address, or any operation to a different address, leaves it intact.
- R10: After reset, `busy`, `rsp_valid` and `rsp_status` are 0 and the link is cleared.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_op | input | 3 | Operation code (see R2) |
| req_addr | input | AW | Word address |
| req_wdata | input | DW | Value to write (store, swap, store-conditional) |
| ctx_switch | input | 1 | Context switch; clears the link |
| busy | output | 1 | Read-modify-write in progress; requests ignored |
| rsp_valid | output | 1 | Response strobe, one cycle |
| rsp_rdata | output | DW | Word value before the operation |
| rsp_status | output | 1 | Store-conditional success |

## Verification
The hardest situations to reach are the races around the link register. These are a context switch that lands on the same edge as a completing load-linked or store-conditional, and a second request held on the port during the busy cycle that must be ignored. The bench reaches them by driving `ctx_switch` exactly in the busy cycle, and by keeping `req_valid` high across that cycle with a different store. Afterwards it reads the words back and attempts follow-up conditional stores, so the hidden link state becomes visible through `rsp_status`. A behavioural model of the memory and the link predicts every response and status.

// File: rtl/asu_pkg.sv
package asu_pkg;
  typedef enum logic [2:0] {
    OP_LOAD  = 3'd0,
    OP_STORE = 3'd1,
    OP_SWAP  = 3'd2,
    OP_TAS   = 3'd3,
    OP_FAI   = 3'd4,
    OP_LL    = 3'd5,
    OP_SC    = 3'd6,
    OP_RSVD  = 3'd7
  } asu_op_e;

  // True for operations that may modify a word other than through the link check.
  function automatic logic is_plain_writer(asu_op_e op);
    return (op == OP_STORE) || (op == OP_SWAP) || (op == OP_TAS) || (op == OP_FAI);
  endfunction
endpackage

// File: rtl/asu_mem.sv
module asu_mem #(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [DW-1:0] wdata,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store_q [DEPTH];

  // Single port, read-first: infers a block RAM.
  always_ff @(posedge clk) begin
    if (we) store_q[addr] <= wdata;
    rdata <= store_q[addr];
  end
endmodule

// File: rtl/asu_link.sv
module asu_link
  import asu_pkg::*;
#(
  parameter int AW = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          exec,
  input  asu_op_e       op,
  input  logic [AW-1:0] addr,
  input  logic          ctx_clear,
  output logic          hit
);
  logic          valid_q;
  logic [AW-1:0] addr_q;

  assign hit = valid_q && (addr_q == addr);

  always_ff @(posedge clk) begin
    if (rst) begin
      valid_q <= 1'b0;
      addr_q  <= '0;
    end else if (ctx_clear) begin
      valid_q <= 1'b0;
    end else if (exec) begin
      if (op == OP_LL) begin
        valid_q <= 1'b1;
        addr_q  <= addr;
      end else if (op == OP_SC) begin
        valid_q <= 1'b0;
      end else if (is_plain_writer(op) && hit) begin
        valid_q <= 1'b0;
      end
    end
  end

  assert_ctx_clears_link_R8: assert property (@(posedge clk) disable iff (rst)
    ctx_clear |=> !valid_q);

  assert_sc_drops_link_R7: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_SC) |=> !valid_q);

  assert_ll_arms_link_R6: assert property (@(posedge clk) disable iff (rst)
    (exec && op == OP_LL && !ctx_clear) |=> (valid_q && addr_q == $past(addr)));

  assert_writer_drops_link_R9: assert property (@(posedge clk) disable iff (rst)
    (exec && is_plain_writer(op) && hit) |=> !valid_q);
endmodule

// File: rtl/asu_alu.sv
module asu_alu
  import asu_pkg::*;
#(
  parameter int DW = 32
) (
  input  asu_op_e       op,
  input  logic [DW-1:0] old_val,
  input  logic [DW-1:0] wdata,
  input  logic          link_hit,
  input  logic          ctx_clear,
  output logic          we,
  output logic [DW-1:0] new_val,
  output logic          sc_ok
);
  localparam logic [DW-1:0] ONE = {{(DW-1){1'b0}}, 1'b1};

  always_comb begin
    we      = 1'b0;
    new_val = wdata;
    sc_ok   = 1'b0;
    unique case (op)
      OP_STORE, OP_SWAP: we = 1'b1;
      OP_TAS: begin
        we      = (old_val == '0);
        new_val = ONE;
      end
      OP_FAI: begin
        we      = 1'b1;
        new_val = old_val + ONE;
      end
      OP_SC: begin
        sc_ok = link_hit && !ctx_clear;
        we    = sc_ok;
      end
      default: we = 1'b0;
    endcase
  end
endmodule

// File: rtl/atomic_sync_unit.sv
module atomic_sync_unit
  import asu_pkg::*;
#(
  parameter int AW = 4,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic [2:0]    req_op,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  input  logic          ctx_switch,
  output logic          busy,
  output logic          rsp_valid,
  output logic [DW-1:0] rsp_rdata,
  output logic          rsp_status
);
  logic          busy_q;
  asu_op_e       op_q;
  logic [AW-1:0] addr_q;
  logic [DW-1:0] wdata_q;
  logic          accept;
  logic [AW-1:0] mem_addr;
  logic [DW-1:0] mem_rdata;
  logic [DW-1:0] alu_new;
  logic          alu_we;
  logic          alu_sc_ok;
  logic          link_hit;

  assign accept   = req_valid && !busy_q;
  assign mem_addr = busy_q ? addr_q : req_addr;
  assign busy     = busy_q;

  asu_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk   (clk),
    .we    (busy_q && alu_we),
    .addr  (mem_addr),
    .wdata (alu_new),
    .rdata (mem_rdata)
  );

  asu_alu #(.DW(DW)) u_alu (
    .op        (op_q),
    .old_val   (mem_rdata),
    .wdata     (wdata_q),
    .link_hit  (link_hit),
    .ctx_clear (ctx_switch),
    .we        (alu_we),
    .new_val   (alu_new),
    .sc_ok     (alu_sc_ok)
  );

  asu_link #(.AW(AW)) u_link (
    .clk       (clk),
    .rst       (rst),
    .exec      (busy_q),
    .op        (op_q),
    .addr      (addr_q),
    .ctx_clear (ctx_switch),
    .hit       (link_hit)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      busy_q     <= 1'b0;
      op_q       <= OP_LOAD;
      addr_q     <= '0;
      wdata_q    <= '0;
      rsp_valid  <= 1'b0;
      rsp_rdata  <= '0;
      rsp_status <= 1'b0;
    end else begin
      rsp_valid  <= 1'b0;
      rsp_status <= 1'b0;
      if (accept) begin
        busy_q  <= 1'b1;
        op_q    <= asu_op_e'(req_op);
        addr_q  <= req_addr;
        wdata_q <= req_wdata;
      end
      if (busy_q) begin
        busy_q     <= 1'b0;
        rsp_valid  <= 1'b1;
        rsp_rdata  <= mem_rdata;
        rsp_status <= alu_sc_ok;
      end
    end
  end

  assert_accept_sets_busy_R1: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !busy) |=> busy);

  assert_busy_one_cycle_R1: assert property (@(posedge clk) disable iff (rst)
    busy |=> (!busy && rsp_valid));

  assert_status_needs_valid_R7: assert property (@(posedge clk) disable iff (rst)
    rsp_status |-> rsp_valid);

  assert_status_only_sc_R7: assert property (@(posedge clk) disable iff (rst)
    (busy && op_q != OP_SC) |=> !rsp_status);
endmodule

// File: tb/atomic_sync_unit_bench.sv
`timescale 1ns/1ps
module atomic_sync_unit_bench;
  localparam int AW = 4;
  localparam int DW = 32;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic          req_valid;
  logic [2:0]    req_op;
  logic [AW-1:0] req_addr;
  logic [DW-1:0] req_wdata;
  logic          ctx_switch;
  logic          busy;
  logic          rsp_valid;
  logic [DW-1:0] rsp_rdata;
  logic          rsp_status;

  always #2.5 clk = ~clk;

  atomic_sync_unit #(.AW(AW), .DW(DW)) u_atomic_sync_unit (
    .clk(clk), .rst(rst), .req_valid(req_valid), .req_op(req_op),
    .req_addr(req_addr), .req_wdata(req_wdata), .ctx_switch(ctx_switch),
    .busy(busy), .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata),
    .rsp_status(rsp_status)
  );

  // Behavioural reference state
  logic [DW-1:0] ref_mem [DEPTH];
  bit            ref_link;
  int            ref_link_addr;
  int            n_tests = 0;
  int            n_fail  = 0;
  bit            done    = 0;

  task automatic chk(bit ok, string tag, logic [DW-1:0] act, logic [DW-1:0] exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // One operation, checked cycle by cycle against the model.
  task automatic run_op(input int op, input int a, input logic [DW-1:0] w,
                        input bit ctx_exec, input bit hold_store, input int hold_addr,
                        input string tag);
    logic [DW-1:0] old;
    bit            exp_ok;
    @(negedge clk);
    req_valid = 1'b1; req_op = op[2:0]; req_addr = a[AW-1:0]; req_wdata = w;
    @(posedge clk);
    @(negedge clk);
    if (hold_store) begin
      req_op = 3'd1; req_addr = hold_addr[AW-1:0]; req_wdata = 32'hDEAD_BEEF;
    end else begin
      req_valid = 1'b0;
    end
    ctx_switch = ctx_exec;
    chk(busy === 1'b1, {tag, " R1 busy"}, {31'b0, busy}, 1);
    chk(rsp_valid === 1'b0, {tag, " R1 no early rsp"}, {31'b0, rsp_valid}, 0);
    old = ref_mem[a];
    exp_ok = 1'b0;
    case (op)
      1, 2: begin ref_mem[a] = w; if (ref_link && ref_link_addr == a) ref_link = 0; end
      3: begin if (old == 0) ref_mem[a] = 1; if (ref_link && ref_link_addr == a) ref_link = 0; end
      4: begin ref_mem[a] = old + 1; if (ref_link && ref_link_addr == a) ref_link = 0; end
      5: begin ref_link = 1; ref_link_addr = a; end
      6: begin
        exp_ok = ref_link && ref_link_addr == a && !ctx_exec;
        if (exp_ok) ref_mem[a] = w;
        ref_link = 0;
      end
      default: ;
    endcase
    if (ctx_exec) ref_link = 0;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0; ctx_switch = 1'b0;
    chk(rsp_valid === 1'b1, {tag, " R1 rsp_valid"}, {31'b0, rsp_valid}, 1);
    chk(busy === 1'b0, {tag, " R1 busy drop"}, {31'b0, busy}, 0);
    chk(rsp_rdata === old, {tag, " R2 old value"}, rsp_rdata, old);
    chk(rsp_status === exp_ok, {tag, " R7 status"}, {31'b0, rsp_status}, {31'b0, exp_ok});
    @(negedge clk);
    chk(rsp_valid === 1'b0, {tag, " R1 single pulse"}, {31'b0, rsp_valid}, 0);
  endtask

  task automatic op_(input int op, input int a, input logic [DW-1:0] w, input string tag);
    run_op(op, a, w, 1'b0, 1'b0, 0, tag);
  endtask

  task automatic ctx_pulse();
    @(negedge clk); ctx_switch = 1'b1;
    @(negedge clk); ctx_switch = 1'b0;
    ref_link = 0;
  endtask

  initial begin
    rst = 1'b1; req_valid = 1'b0; req_op = '0; req_addr = '0; req_wdata = '0; ctx_switch = 1'b0;
    ref_link = 0; ref_link_addr = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    chk(busy === 1'b0, "R10 busy after reset", {31'b0, busy}, 0);
    chk(rsp_valid === 1'b0, "R10 rsp_valid after reset", {31'b0, rsp_valid}, 0);
    chk(rsp_status === 1'b0, "R10 status after reset", {31'b0, rsp_status}, 0);
    // R10: no link after reset -> store-conditional fails (after init)
    for (int i = 0; i < DEPTH; i++) begin
      ref_mem[i] = 'x;
      op_(1, i, 32'(i * 3), "R2 init store");
    end
    op_(6, 4, 32'h55, "R10 SC without link");
    // R3 lock via swap
    op_(1, 1, 0, "R3 free lock");
    op_(2, 1, 1, "R3 swap acquire");
    op_(2, 1, 1, "R3 swap held");
    op_(2, 1, 32'h1234_5678, "R3 swap arbitrary");
    // R4 test-and-set
    op_(1, 2, 0, "R4 clear");
    op_(3, 2, 0, "R4 tas free");
    op_(3, 2, 0, "R4 tas held");
    op_(1, 3, 5, "R4 set 5");
    op_(3, 3, 0, "R4 tas nonzero");
    op_(0, 3, 0, "R4 unchanged");
    // R5 fetch-and-increment with wrap
    op_(1, 5, 0, "R5 clear");
    op_(4, 5, 0, "R5 fai 0");
    op_(4, 5, 0, "R5 fai 1");
    op_(1, 6, 32'hFFFF_FFFF, "R5 all ones");
    op_(4, 6, 0, "R5 fai wrap");
    op_(0, 6, 0, "R5 wrapped");
    // R6 / R7 load-linked and store-conditional
    op_(5, 7, 0, "R6 LL");
    op_(6, 7, 32'hA5A5, "R7 SC success");
    op_(6, 7, 32'hBBBB, "R7 SC after SC");
    op_(0, 7, 0, "R7 failed SC no write");
    op_(5, 8, 0, "R6 LL 8");
    op_(5, 9, 0, "R6 LL 9 replaces");
    op_(6, 8, 32'h1, "R6 SC old addr");
    op_(6, 9, 32'h2, "R6 SC new addr cleared");
    // R9 writers on linked address
    op_(5, 10, 0, "R9 LL");
    op_(1, 10, 32'h77, "R9 store linked");
    op_(6, 10, 32'h88, "R9 SC after store");
    op_(5, 10, 0, "R9 LL");
    op_(4, 10, 0, "R9 fai linked");
    op_(6, 10, 32'h88, "R9 SC after fai");
    op_(5, 10, 0, "R9 LL");
    op_(3, 10, 0, "R9 tas linked nonzero");
    op_(6, 10, 32'h88, "R9 SC after tas");
    op_(5, 11, 0, "R9 LL");
    op_(0, 11, 0, "R9 load keeps");
    op_(2, 12, 9, "R9 other addr");
    op_(6, 11, 32'h99, "R9 SC kept");
    // R2 reserved code
    op_(5, 13, 0, "R2 LL");
    op_(7, 13, 32'hFFFF, "R2 reserved");
    op_(0, 13, 0, "R2 reserved no write");
    op_(6, 13, 32'h44, "R2 reserved keeps link");
    // R8 context switch
    op_(5, 14, 0, "R8 LL");
    ctx_pulse();
    op_(6, 14, 32'h66, "R8 SC after ctx");
    op_(5, 14, 0, "R8 LL");
    run_op(6, 14, 32'h67, 1'b1, 1'b0, 0, "R8 ctx on SC edge");
    op_(0, 14, 0, "R8 no write");
    run_op(5, 15, 0, 1'b1, 1'b0, 0, "R8 ctx on LL edge");
    op_(6, 15, 32'h68, "R8 LL lost");
    // R1 request held while busy is ignored
    op_(1, 0, 32'hCAFE, "R1 setup");
    run_op(0, 4, 0, 1'b0, 1'b1, 0, "R1 held request");
    op_(0, 0, 0, "R1 ignored store");
    done = 1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      n_tests++; n_fail++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end
endmodule